// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital half of a dual-slope integrating converter. It steers three analog switches around an external integrator and reads one comparator bit that is high while the integrator output lies above its starting level. A single start request runs one conversion. First the integrator capacitor is discharged. Next the unknown input is integrated for a fixed number of clocks. Last, a reference of opposite polarity is applied while the sequencer counts clocks until the comparator reports that the integrator has returned to its start level.

That count is the conversion result. It is presented together with a one-cycle completion strobe. One clock times both the fixed and the counted interval, so any error in the clock rate scales both intervals equally and drops out of the ratio. If the comparator never drops, a count ceiling ends the reference interval and raises an overrange flag. All three phase lengths are parameters.

Top module: `dslope_seq`

## Requirements
- R1: While reset is held and after it is released, all three switch outputs, `busy_o`, `done_o`, `overrange_o` and `result_o` are 0 until a conversion is started.
- R2: A `start_i` sampled high while idle makes `sw_zero_o` active from the next cycle for exactly `AZ_CYCLES` cycles.
- R3: The discharge phase is followed at once by exactly `INT_CYCLES` cycles with `sw_input_o` active.
- R4: The input phase is followed at once by `sw_ref_o` active. The reference phase lasts until the first cycle in which `cmp_above_i` is sampled low, and that cycle is included in the phase.
- R5: At the end of a normal reference phase, `result_o` equals the number of reference-phase cycles in which `cmp_above_i` was high. `done_o` is high for exactly one cycle, the cycle after the last reference cycle, and `overrange_o` is 0.
- R6: If `cmp_above_i` is high in `MAX_COUNT` consecutive reference cycles, the phase ends after the last of them. `result_o` then equals `MAX_COUNT`, `overrange_o` is 1 and `done_o` pulses in the next cycle.
- R7: If `cmp_above_i` goes low in the reference cycle that follows exactly `MAX_COUNT-1` high cycles, the conversion ends normally with result `MAX_COUNT-1` and no overrange.
- R8: At most one switch output is active in any cycle, and none is active while `busy_o` is 0. `busy_o` is high exactly during the three phases.
- R9: `start_i` has no effect while a conversion is in progress.
- R10: `result_o` and `overrange_o` change only in a cycle in which `done_o` is high, and they hold their values until the next such cycle.
- R11: A `start_i` sampled high in the cycle in which `done_o` is high begins a new conversion on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that times every phase |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_above_i | input | 1 | Comparator: 1 while the integrator is above its start level |
| sw_zero_o | output | 1 | Closes the capacitor discharge switch |
| sw_input_o | output | 1 | Connects the unknown input to the integrator |
| sw_ref_o | output | 1 | Connects the opposite-polarity reference |
| busy_o | output | 1 | A conversion is in progress |
| done_o | output | 1 | One-cycle strobe: a new result is valid |
| overrange_o | output | 1 | The last conversion hit the count ceiling |
| result_o | output | $clog2(MAX_COUNT+1) | Reference-phase count of the last conversion |

## Verification
Two events can fall in the same reference cycle: the comparator dropping low, and the count reaching its ceiling. When they coincide, the crossing must win. The bench drives the sequencer in closed loop with an integer integrator model, and it picks input magnitudes so that the crossing lands exactly on the cycle after `MAX_COUNT-1` high samples. It also picks magnitudes one step beyond that, and requires a normal result of `MAX_COUNT-1` in the first case and an overrange of `MAX_COUNT` in the second. A start that coincides with the completion strobe is also driven. The bench checks that it launches the next conversion without an idle gap.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_AZERO  = 2'd1,
    PH_SIGNAL = 2'd2,
    PH_REFER  = 2'd3
  } phase_e;

  localparam int unsigned NUM_SW = 3;

endpackage

// File: rtl/dslope_phase_timer.sv
module dslope_phase_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_we;

  always_comb begin
    cnt_we = clr_i | en_i;
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/dslope_sw_decode.sv
module dslope_sw_decode
  import dslope_pkg::*;
(
  input  phase_e            phase_i,
  output logic [NUM_SW-1:0] sw_o,
  output logic              busy_o
);

  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    assign sw_o[i] = (phase_i == phase_e'(2'(i + 1)));
  end

  assign busy_o = (phase_i != PH_IDLE);

endmodule

// File: rtl/dslope_ctrl.sv
module dslope_ctrl
  import dslope_pkg::*;
#(
  parameter int unsigned AZ_CYCLES  = 8,
  parameter int unsigned INT_CYCLES = 256,
  parameter int unsigned MAX_COUNT  = 512,
  parameter int unsigned TW         = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          cmp_above_i,
  output phase_e        phase_o,
  output logic [TW-1:0] cnt_o,
  output logic          fin_norm_o,
  output logic          fin_over_o
);

  localparam logic [TW-1:0] AZ_LAST  = TW'(AZ_CYCLES - 1);
  localparam logic [TW-1:0] INT_LAST = TW'(INT_CYCLES - 1);
  localparam logic [TW-1:0] REF_LAST = TW'(MAX_COUNT - 1);

  phase_e        state_q;
  phase_e        state_d;
  logic          tmr_clr;
  logic          tmr_en;
  logic [TW-1:0] tmr_cnt;

  dslope_phase_timer #(.W(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (tmr_clr),
    .en_i  (tmr_en),
    .cnt_o (tmr_cnt)
  );

  always_comb begin
    state_d    = state_q;
    tmr_clr    = 1'b0;
    tmr_en     = 1'b0;
    fin_norm_o = 1'b0;
    fin_over_o = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (start_i) begin
          state_d = PH_AZERO;
          tmr_clr = 1'b1;
        end
      end
      PH_AZERO: begin
        if (tmr_cnt == AZ_LAST) begin
          state_d = PH_SIGNAL;
          tmr_clr = 1'b1;
        end else begin
          tmr_en = 1'b1;
        end
      end
      PH_SIGNAL: begin
        if (tmr_cnt == INT_LAST) begin
          state_d = PH_REFER;
          tmr_clr = 1'b1;
        end else begin
          tmr_en = 1'b1;
        end
      end
      PH_REFER: begin
        if (!cmp_above_i) begin
          fin_norm_o = 1'b1;
          state_d    = PH_IDLE;
        end else if (tmr_cnt == REF_LAST) begin
          fin_over_o = 1'b1;
          state_d    = PH_IDLE;
        end else begin
          tmr_en = 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_IDLE;
    else        state_q <= state_d;
  end

  assign phase_o = state_q;
  assign cnt_o   = tmr_cnt;

endmodule

// File: rtl/dslope_result.sv
module dslope_result #(
  parameter int unsigned MAX_COUNT = 512,
  parameter int unsigned TW        = 10,
  parameter int unsigned CW        = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fin_norm_i,
  input  logic          fin_over_i,
  input  logic [TW-1:0] cnt_i,
  output logic [CW-1:0] result_o,
  output logic          overrange_o,
  output logic          done_o
);

  logic [CW-1:0] res_q;
  logic [CW-1:0] res_d;
  logic          ovr_q;
  logic          done_q;
  logic          cap_en;

  always_comb begin
    cap_en = fin_norm_i | fin_over_i;
    if (fin_over_i) res_d = CW'(MAX_COUNT);
    else            res_d = CW'(cnt_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ovr_q <= 1'b0;
    end else if (cap_en) begin
      res_q <= res_d;
      ovr_q <= fin_over_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= cap_en;
  end

  assign result_o    = res_q;
  assign overrange_o = ovr_q;
  assign done_o      = done_q;

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int unsigned AZ_CYCLES  = 8,
  parameter int unsigned INT_CYCLES = 256,
  parameter int unsigned MAX_COUNT  = 512,
  localparam int unsigned CW = $clog2(MAX_COUNT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          cmp_above_i,
  output logic          sw_zero_o,
  output logic          sw_input_o,
  output logic          sw_ref_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          overrange_o,
  output logic [CW-1:0] result_o
);

  localparam int unsigned M1   = (AZ_CYCLES > INT_CYCLES) ? AZ_CYCLES : INT_CYCLES;
  localparam int unsigned MAXV = (M1 > MAX_COUNT) ? M1 : MAX_COUNT;
  localparam int unsigned TW   = $clog2(MAXV + 1);

  phase_e            phase;
  logic [TW-1:0]     cnt;
  logic              fin_norm;
  logic              fin_over;
  logic [NUM_SW-1:0] sw;

  dslope_ctrl #(
    .AZ_CYCLES  (AZ_CYCLES),
    .INT_CYCLES (INT_CYCLES),
    .MAX_COUNT  (MAX_COUNT),
    .TW         (TW)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cmp_above_i (cmp_above_i),
    .phase_o     (phase),
    .cnt_o       (cnt),
    .fin_norm_o  (fin_norm),
    .fin_over_o  (fin_over)
  );

  dslope_sw_decode u_dec (
    .phase_i (phase),
    .sw_o    (sw),
    .busy_o  (busy_o)
  );

  dslope_result #(
    .MAX_COUNT (MAX_COUNT),
    .TW        (TW),
    .CW        (CW)
  ) u_res (
    .clk         (clk),
    .rst_n       (rst_n),
    .fin_norm_i  (fin_norm),
    .fin_over_i  (fin_over),
    .cnt_i       (cnt),
    .result_o    (result_o),
    .overrange_o (overrange_o),
    .done_o      (done_o)
  );

  assign sw_zero_o  = sw[0];
  assign sw_input_o = sw[1];
  assign sw_ref_o   = sw[2];

endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
  parameter int unsigned MAX_COUNT = 512,
  parameter int unsigned CW        = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_zero_o,
  input logic          sw_input_o,
  input logic          sw_ref_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          overrange_o,
  input logic [CW-1:0] result_o
);

  assert_one_switch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sw_zero_o, sw_input_o, sw_ref_o}) <= 1);

  assert_idle_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(sw_zero_o || sw_input_o || sw_ref_o));

  assert_start_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> sw_zero_o);

  assert_input_then_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_input_o |=> (sw_input_o || sw_ref_o));

  assert_ref_end_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_ref_o) |-> done_o);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_over_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && overrange_o) |-> (result_o == CW'(MAX_COUNT)));

  assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(result_o) && $stable(overrange_o)));

endmodule

bind dslope_seq dslope_seq_chk #(.MAX_COUNT(MAX_COUNT), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sw_zero_o   (sw_zero_o),
  .sw_input_o  (sw_input_o),
  .sw_ref_o    (sw_ref_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .overrange_o (overrange_o),
  .result_o    (result_o)
);

// File: tb/dslope_seq_test.sv
module dslope_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int AZ   = 4;
  localparam int INTN = 16;
  localparam int MAXC = 40;
  localparam int VREF = 5;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int WATCHDOG = 20000;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic          cmp_above_i;
  logic          sw_zero_o, sw_input_o, sw_ref_o, busy_o, done_o, overrange_o;
  logic [CW-1:0] result_o;

  int vectors;
  int miscompares;
  int vin_r;
  int integ;

  // behavioural model: expected phase code per cycle
  // 0 idle, 1 discharge, 2 input, 3 reference, 4 idle with done
  int q[$];
  int cur;
  int exp_res;
  int exp_ov;
  int held_res;
  int held_ov;

  dslope_seq #(
    .AZ_CYCLES  (AZ),
    .INT_CYCLES (INTN),
    .MAX_COUNT  (MAXC)
  ) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cmp_above_i (cmp_above_i),
    .sw_zero_o   (sw_zero_o),
    .sw_input_o  (sw_input_o),
    .sw_ref_o    (sw_ref_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .overrange_o (overrange_o),
    .result_o    (result_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // integer integrator driven by the switch outputs
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)          integ <= 0;
    else if (sw_zero_o)  integ <= 0;
    else if (sw_input_o) integ <= integ + vin_r;
    else if (sw_ref_o)   integ <= integ - VREF;
  end
  assign cmp_above_i = (integ > 0);

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      cur = 0;
    end else begin
      if (start_i && (cur == 0 || cur == 4) && q.size() == 0) begin
        int k;
        int nref;
        k = (vin_r * INTN + VREF - 1) / VREF;
        if (k >= MAXC) begin
          exp_res = MAXC; exp_ov = 1; nref = MAXC;
        end else begin
          exp_res = k; exp_ov = 0; nref = k + 1;
        end
        for (int i = 0; i < AZ; i++)   q.push_back(1);
        for (int i = 0; i < INTN; i++) q.push_back(2);
        for (int i = 0; i < nref; i++) q.push_back(3);
        q.push_back(4);
      end
      if (q.size() > 0) cur = q.pop_front();
      else              cur = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      string tg;
      case (cur)
        1:       tg = "R2 discharge switches";
        2:       tg = "R3 input switches";
        3:       tg = "R4 reference switches";
        default: tg = "R8 idle switches";
      endcase
      chk(tg, {sw_zero_o, sw_input_o, sw_ref_o},
          {cur == 1, cur == 2, cur == 3});
      chk("R8 busy", busy_o, (cur >= 1 && cur <= 3));
      chk("R5 done strobe", done_o, (cur == 4));
      if (cur == 4) begin
        chk(exp_ov ? "R6 overrange result" : "R5 result", result_o, exp_res);
        chk(exp_ov ? "R6 overrange flag" : "R7 no overrange flag", overrange_o, exp_ov);
        held_res = exp_res;
        held_ov  = exp_ov;
      end else begin
        chk("R10 result held", result_o, held_res);
        chk("R10 overrange held", overrange_o, held_ov);
      end
    end
  end

  task automatic launch(input int vin);
    vin_r   = vin;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
  endtask

  task automatic run_all();
    rst_n   = 1'b0;
    start_i = 1'b0;
    vin_r   = 0;
    held_res = 0;
    held_ov  = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset switches", {sw_zero_o, sw_input_o, sw_ref_o}, 0);
    chk("R1 reset busy", busy_o, 0);
    chk("R1 reset done", done_o, 0);
    chk("R1 reset result", result_o, 0);
    chk("R1 reset overrange", overrange_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    launch(0);  wait_done();          // R5 zero input, immediate crossing
    repeat (2) @(negedge clk);
    launch(3);  wait_done();          // R5 result 10
    repeat (2) @(negedge clk);
    launch(7);                        // R9 start pulsed mid conversion
    repeat (3) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    repeat (2) @(negedge clk);
    launch(12); wait_done();          // R7 crossing at MAX-1
    repeat (2) @(negedge clk);
    launch(13); wait_done();          // R6 overrange
    repeat (2) @(negedge clk);
    launch(5);  wait_done();          // R11 back-to-back start
    launch(9);  wait_done();
    launch(20); wait_done();          // R6 larger overrange, chained (R11)
    launch(1);  wait_done();          // R5 after overrange clears flag
    repeat (4) @(negedge clk);
  endtask

  initial begin
    vectors     = 0;
    miscompares = 0;
    fork
      run_all();
      begin
        repeat (WATCHDOG) @(posedge clk);
        miscompares++;
        $display("FAIL R5 watchdog actual=no_done expected=done");
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule